// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is the management-bus master of an Ethernet port. Software places one 32-bit command word in the block. The word names the frame format, the PHY address, the register or device address, the operation and sixteen data bits. Setting the start bit sends exactly one management frame on MDC/MDIO. The start bit reads back as 1 while the frame is on the wire. The hardware clears it once the last bit has been clocked out. For read frames, the sixteen bits sampled from the PHY then sit in the upper half of the same word.

A separate configuration word sets the MDC half-period and the number of system clocks MDIO waits after an MDC falling edge before it moves. Both frame formats are supported. An indirect (Clause 45) access takes two commands from software: first an address frame, then the read or write frame. Software waits for the start bit to drop between them. The register interface is a plain write strobe with read-back buses and has no back-pressure: the only flow control is the start/busy bit, and the block silently refuses a command word written while it is set.

Top module: `mdio_station`

## Requirements
- R1: Writing the command word with bit 0 = 1 while bit 0 reads 0 launches one frame. Bit 0 reads 1 from the next cycle until the frame ends, then reads 0.
- R2: A command-word write while bit 0 reads 1 has no effect: the frame in flight and every field of the command word stay as they were, and no further frame follows.
- R3: Each frame is sent MSB first. It starts with 32 ones, then a 2-bit start code, 01 when bit 2 is 0 (Clause 22) and 00 when bit 2 is 1 (Clause 45). Then come the opcode (bits 14:13 sent unchanged), the PHY address (bits 7:3) and the register/device address (bits 12:8).
- R4: For opcodes 0 (address) and 1 (write), all 64 bits are driven: the turnaround is sent as 1 then 0, followed by bits 31:16. After the frame those bits still read back unchanged.
- R5: For opcodes 2 and 3 (reads), MDIO output enable is low for bits 46 to 63 of the frame. Sixteen bits are sampled on MDC rising edges, MSB first, and after completion they read back in bits 31:16.
- R6: MDC low and high phases inside a frame each last (D + 1) system clocks, where D is configuration bits 22:16.
- R7: Within each MDC low phase, MDIO changes only on the clock edge that is min(H, D) clocks after the falling edge, where H is configuration bits 26:24.
- R8: After reset the command word reads 0. Outside frames MDC is high and MDIO output enable is low.
- R9: The configuration word reads back only bits 22:16 and 26:24; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write value |
| cmd_word | output | 32 | Command word read-back (bit 0 = busy) |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word write value |
| cfg_word | output | 32 | Configuration word read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest case to reach is the hold-time placement of MDIO edges relative to MDC. It can only be observed where a frame bit differs from the one before it, and it folds in the clamp to the half-period whenever the hold count exceeds the divider. The stimulus varies the divider and hold settings from frame to frame, including hold larger than divider, divider 0 and the largest divider. It measures the delay at every data transition, and the preamble-to-start-code edge guarantees at least one transition per frame. A PHY model drives read bits after each MDC rise so that the sampled data can be compared with what was sent.

// File: rtl/mdio_station_pkg.sv
package mdio_station_pkg;
  localparam int CMD_W     = 32;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int DIV_W     = 7;
  localparam int HOLD_W    = 3;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_POS    = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_POS  = TA_POS + 2;
  localparam int DIV_LSB   = 16;
  localparam int HOLD_LSB  = 24;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RD22  = 2'd2,
    OP_RD45  = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] payload;
    logic              spare_hi;
    mgmt_op_e          op;
    logic [ADDR_W-1:0] reg_dev;
    logic [ADDR_W-1:0] port_addr;
    logic              ext_fmt;
    logic              spare_lo;
    logic              go;
  } cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_station_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase_hi,
  output logic [DIV_W-1:0] cnt,
  output logic             half_end,
  output logic             mdc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (cnt >= div) begin
      cnt      <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign half_end = run && (cnt >= div);
  assign mdc      = ~run | phase_hi;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_station_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 is_read,
  input  logic [DIV_W-1:0]     div,
  input  logic [HOLD_W-1:0]    hold,
  input  logic                 phase_hi,
  input  logic [DIV_W-1:0]     cnt,
  input  logic                 half_end,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rdata,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

  logic [FRAME_LEN-1:0] frame_q;
  logic                 rd_q;
  logic [IDX_W-1:0]     idx;
  logic [IDX_W-1:0]     idx_nxt;
  logic [DIV_W-1:0]     hold_ext, hold_eff;
  logic                 bit_end, rise, mid_set, edge_set, last;

  assign hold_ext = DIV_W'(hold);
  assign hold_eff = (hold_ext > div) ? div : hold_ext;
  assign last     = (idx == LAST_IDX);
  assign idx_nxt  = idx + 1'b1;
  assign bit_end  = busy && phase_hi && half_end;
  assign rise     = busy && !phase_hi && half_end;
  assign mid_set  = busy && !phase_hi && (hold_eff != '0) && (cnt == hold_eff - 1'b1);
  assign edge_set = bit_end && !last && (hold_eff == '0);
  assign done     = bit_end && last;

  function automatic logic bit_at(input logic [FRAME_LEN-1:0] f, input logic [IDX_W-1:0] i);
    logic [IDX_W-1:0] pos;
    pos = LAST_IDX - i;
    return f[pos];
  endfunction

  function automatic logic drive_at(input logic rd, input logic [IDX_W-1:0] i);
    return !(rd && (i >= TA_IDX));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      frame_q <= '0;
      rd_q    <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      idx     <= '0;
      frame_q <= frame_in;
      rd_q    <= is_read;
      rdata   <= '0;
      mdio_o  <= frame_in[FRAME_LEN-1];
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise && rd_q && (idx >= DATA_IDX)) begin
        rdata <= {rdata[DATA_W-2:0], mdio_i};
      end
      if (bit_end) begin
        if (last) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx <= idx_nxt;
        end
      end
      if (edge_set) begin
        mdio_o  <= bit_at(frame_q, idx_nxt);
        mdio_oe <= drive_at(rd_q, idx_nxt);
      end
      if (mid_set) begin
        mdio_o  <= bit_at(frame_q, idx);
        mdio_oe <= drive_at(rd_q, idx);
      end
    end
  end

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q && (idx > TA_IDX)) |-> !mdio_oe);

  assert_index_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && phase_hi && half_end) |=> !busy);
endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_station_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_word,
  input  logic              cfg_we,
  input  logic [CMD_W-1:0]  cfg_wdata,
  output logic [CMD_W-1:0]  cfg_word,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [CMD_W-1:0] CFG_MASK =
    (CMD_W'((1 << DIV_W) - 1) << DIV_LSB) | (CMD_W'((1 << HOLD_W) - 1) << HOLD_LSB);

  logic [CMD_W-1:1]     cmd_q;
  logic [CMD_W-1:0]     cfg_q;
  logic [DIV_W-1:0]     div;
  logic [HOLD_W-1:0]    hold;
  cmd_t                 wr, cur;
  logic                 busy, done, accept, start;
  logic [FRAME_LEN-1:0] frame;
  logic [DATA_W-1:0]    rdata;
  logic                 phase_hi, half_end;
  logic [DIV_W-1:0]     cnt;

  assign wr     = cmd_t'(cmd_wdata);
  assign cur    = cmd_t'({cmd_q, 1'b0});
  assign accept = cmd_we && !busy;
  assign start  = accept && wr.go;
  assign div    = cfg_q[DIV_LSB +: DIV_W];
  assign hold   = cfg_q[HOLD_LSB +: HOLD_W];

  assign frame = {{PRE_LEN{1'b1}}, 1'b0, ~wr.ext_fmt, wr.op, wr.port_addr, wr.reg_dev,
                  2'b10, wr.payload};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cfg_q <= '0;
    end else begin
      if (accept) begin
        cmd_q <= cmd_wdata[CMD_W-1:1];
      end else if (done && cur.op[1]) begin
        cmd_q[CMD_W-1 -: DATA_W] <= rdata;
      end
      if (cfg_we) begin
        cfg_q <= cfg_wdata;
      end
    end
  end

  assign cmd_word = {cmd_q, busy};
  assign cfg_word = cfg_q & CFG_MASK;

  mdio_clk_div u_clk_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (div),
    .phase_hi (phase_hi),
    .cnt      (cnt),
    .half_end (half_end),
    .mdc      (mdc)
  );

  mdio_frame_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .frame_in (frame),
    .is_read  (wr.op[1]),
    .div      (div),
    .hold     (hold),
    .phase_hi (phase_hi),
    .cnt      (cnt),
    .half_end (half_end),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !cmd_word[0] && cmd_wdata[0]) |=> cmd_word[0]);

  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_word[0] && cmd_we && !done) |=> $stable(cmd_word[CMD_W-1:1]));

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_word[0] |-> (mdc && !mdio_oe));

  assert_data_moves_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> !mdc);
endmodule

// File: tb/mdio_station_bench.sv
module mdio_station_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_word;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_word;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_station u_mdio_station (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_word(cmd_word),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_word(cfg_word),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model and frame capture on MDC rising edges
  logic [63:0] cap_d, cap_e;
  int          k = 0;
  logic [15:0] phy_val = '0;
  always @(posedge mdc) begin
    if (k < 64) begin
      cap_d[63-k] = mdio_o;
      cap_e[63-k] = mdio_oe;
    end
    k = k + 1;
    if (k >= 48 && k < 64) mdio_i <= phy_val[63-k];
  end

  // Timing monitor, sampled mid-cycle
  logic prev_mdc = 1'b1, prev_o = 1'b1, in_hi = 1'b0;
  int lowcnt = 0, highcnt = 0, exp_half = 1, exp_hold = 1;
  int bad_low = 0, bad_high = 0, bad_hold = 0, n_hold = 0;
  always @(negedge clk) if (rst_n) begin
    if (!mdc) begin
      if (prev_mdc) begin
        if (in_hi && highcnt != exp_half) bad_high++;
        lowcnt = 1;
      end else lowcnt++;
      if (mdio_o !== prev_o && cmd_word[0]) begin
        n_hold++;
        if (lowcnt != exp_hold) bad_hold++;
      end
    end else begin
      if (!prev_mdc) begin
        if (lowcnt != exp_half) bad_low++;
        highcnt = 1;
        in_hi = 1'b1;
      end else highcnt++;
    end
    if (!cmd_word[0]) in_hi = 1'b0;
    prev_mdc = mdc;
    prev_o = mdio_o;
  end

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 1'b0, ~w[2], w[14:13], w[7:3], w[12:8], 2'b10, w[31:16]};
  endfunction

  task automatic set_cfg(input int dv, input int hd);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = (32'(hd) << 24) | (32'(dv) << 16);
    @(negedge clk);
    cfg_we = 1'b0;
    exp_half = dv + 1;
    exp_hold = ((hd > dv) ? dv : hd) + 1;
  endtask

  task automatic launch(input logic [31:0] w, input logic [15:0] rv);
    phy_val = rv;
    k = 0;
    bad_low = 0; bad_high = 0; bad_hold = 0; n_hold = 0;
    @(negedge clk);
    cmd_we = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(cmd_word[0] == 1'b1, "R1 busy after launch", 64'(cmd_word[0]), 64'd1);
  endtask

  task automatic wait_idle();
    while (cmd_word[0]) @(negedge clk);
  endtask

  task automatic check_frame(input logic [31:0] w, input logic [15:0] rv, input bit timing);
    logic [63:0] ef, em;
    bit rd;
    rd = w[14];
    ef = exp_frame(w);
    em = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    chk(k == 64, "R1 one frame of 64 bits", 64'(k), 64'd64);
    chk(cap_e == em, rd ? "R5 output enable released" : "R4 all bits driven", cap_e, em);
    chk((cap_d & em) == (ef & em), "R3 frame bits", cap_d & em, ef & em);
    chk(cmd_word == {rd ? rv : w[31:16], w[15:1], 1'b0},
        rd ? "R5 read data returned" : "R4 data field kept",
        64'(cmd_word), 64'({rd ? rv : w[31:16], w[15:1], 1'b0}));
    if (timing) begin
      chk(bad_low == 0 && bad_high == 0, "R6 MDC half-period",
          64'(bad_low + bad_high), 64'd0);
      chk(bad_hold == 0 && n_hold > 0, "R7 MDIO hold placement",
          64'(bad_hold), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, w2;
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(cmd_word == 32'd0, "R8 command word after reset", 64'(cmd_word), 64'd0);
    chk(mdc == 1'b1 && mdio_oe == 1'b0, "R8 idle bus after reset", {mdc, mdio_oe}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdc == 1'b1 && mdio_oe == 1'b0, "R8 idle bus", {mdc, mdio_oe}, 2'b10);

    // R9 configuration read-back mask
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_word == 32'h077F_0000, "R9 config read-back", 64'(cfg_word), 64'h077F_0000);

    // Sweep format x opcode x pattern, varying divider and hold per frame
    for (int fmt = 0; fmt < 2; fmt++) begin
      for (int op = 0; op < 4; op++) begin
        for (int pat = 0; pat < 3; pat++) begin
          set_cfg(pat + op, (fmt * 4 + op + pat * 3) % 8);
          w = {16'hA5C3 ^ 16'(pat * 16'h1357), 1'b0, 2'(op), 5'(pat * 9 + fmt * 3 + 1),
               5'(pat * 7 + op), 1'(fmt), 1'b0, 1'b1};
          rv = 16'h3C5A + 16'(pat * 16'h0F1) + 16'(op);
          launch(w, rv);
          wait_idle();
          check_frame(w, rv, 1'b1);
          @(negedge clk);
          chk(mdc == 1'b1 && mdio_oe == 1'b0, "R8 idle between frames", {mdc, mdio_oe}, 2'b10);
        end
      end
    end

    // Programmed hold of 6 with the largest divider, Clause 45 read
    set_cfg(127, 6);
    w = {16'h0000, 1'b0, 2'd3, 5'd30, 5'd17, 1'b1, 1'b0, 1'b1};
    launch(w, 16'hBEEF);
    wait_idle();
    check_frame(w, 16'hBEEF, 1'b1);

    // Divider 0, hold above divider
    set_cfg(0, 6);
    w = {16'h8001, 1'b0, 2'd1, 5'd5, 5'd31, 1'b0, 1'b0, 1'b1};
    launch(w, 16'h0);
    wait_idle();
    check_frame(w, 16'h0, 1'b1);

    // R2 write while busy is ignored
    set_cfg(2, 1);
    w  = {16'h1234, 1'b0, 2'd1, 5'd3, 5'd9, 1'b0, 1'b0, 1'b1};
    w2 = {16'hFFFF, 1'b1, 2'd2, 5'd31, 5'd31, 1'b1, 1'b1, 1'b1};
    launch(w, 16'h0);
    repeat (20) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w2;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(cmd_word == {w[31:1], 1'b1}, "R2 fields unchanged by busy write",
        64'(cmd_word), 64'({w[31:1], 1'b1}));
    wait_idle();
    check_frame(w, 16'h0, 1'b0);
    repeat (200) @(negedge clk);
    chk(k == 64 && cmd_word[0] == 1'b0, "R2 no extra frame", 64'(k), 64'd64);

    // R1 write with start bit clear stores fields without a frame
    @(negedge clk);
    k = 0;
    cmd_we = 1'b1; cmd_wdata = 32'h5555_AAAA;
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (50) @(negedge clk);
    chk(k == 0 && cmd_word == 32'h5555_AAAA, "R1 no launch without start bit",
        64'(cmd_word), 64'h5555_AAAA);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule